// File: doc/BRIEF.md
# Fly-by DMA Channel Engine with Buffer Chaining

This block moves data between peripherals on a general-purpose bus and system memory in single-cycle (fly-by) transfers. Memory is driven with an address, a strobe and a write-enable. The peripheral sees only an acknowledge line on its own request/acknowledge pair. The data item goes straight between the two on the shared data bus, and the engine never holds it. Each transfer takes one strobe cycle. The address of the active buffer steps by one item after each transfer, and its count steps down by one.

Each channel can be steered to any of the request inputs. When several enabled channels have an active request at once, the lowest-numbered channel wins. A channel may also run in chaining mode. In that mode software loads a second buffer (address and count) and marks it valid while the first buffer is still running. When the first buffer's count runs out, the engine takes over the second buffer by itself and raises a buffer-switch flag, so software can refill the slot. If no valid buffer is waiting, the channel stops and raises a terminal-count flag. Address and count registers are wider than 16 bits and are set by parameters.

Top module: `fbdma_top`

## Requirements
- R1: After reset, mem_stb, tc_o, every dack line and every irq bit are 0, and every register reads back 0.
- R2: A request held high on a line routed to an enabled, idle channel produces a memory strobe in the cycle after the request is sampled. The strobe lasts exactly one cycle. Between transfers the channel is idle for at least one cycle. dack is one-hot while mem_stb is high and all-zero otherwise.
- R3: mem_addr shows the channel's current address, which goes up by one after each transfer that is not the last of its buffer. mem_we equals the channel's direction bit (control bit 2; 1 = peripheral to memory).
- R4: A count value of N-1 gives exactly N transfers. tc_o is high together with mem_stb on the last transfer of every buffer.
- R5: At terminal count, with chaining off (control bit 1 = 0) or with the next-valid bit clear, the channel clears its enable bit (control bit 0), sets status bit 1 and makes no more transfers, even while its request stays high.
- R6: At terminal count, with chaining on and next-valid (status bit 0) set, the channel loads the next address and count, clears next-valid, sets status bit 2 and goes on transferring from the new address with no software action.
- R7: Control bits [8 +: log2(NREQ)] choose which request input serves the channel. The acknowledge is driven on that same line.
- R8: Among channels requesting in the same cycle, the lowest channel number is served first.
- R9: Register address = {channel, select}, with select 0 = control, 1 = current address, 2 = current count, 3 = next address, 4 = next count, 5 = status. After a buffer stops, the current address reads as the address of its last transfer and the count reads 0.
- R10: irq[c] = status bit 1 OR status bit 2 of channel c. Writing 1 to status bit 1 or bit 2 clears that flag. irq never changes in a cycle that has neither a register write nor a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | NREQ | Peripheral request lines |
| dack | output | NREQ | Peripheral acknowledge lines, high during the strobe |
| mem_addr | output | AW | Memory item address |
| mem_stb | output | 1 | Memory transfer strobe |
| mem_we | output | 1 | Memory write (peripheral to memory) |
| tc_o | output | 1 | Last transfer of a buffer |
| irq | output | NCH | Per-channel interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | log2(NCH)+3 | Register address {channel, select} |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |

## Verification
The assertions check on every cycle that the strobe is one cycle long, that acknowledge and strobe line up and are one-hot, that each strobe follows a sampled request on its acknowledged line, that terminal count only comes with a strobe, and that irq stays put when nothing touches it. Only the bench scenarios can show address sequences, transfer counts per programmed count, the automatic buffer switch in chaining mode, fixed-priority order and route selection, because each of these depends on what software programmed earlier.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_CADDR = 3'd1,
        SEL_CCNT  = 3'd2,
        SEL_NADDR = 3'd3,
        SEL_NCNT  = 3'd4,
        SEL_STAT  = 3'd5
    } reg_sel_e;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_CHAIN = 1;
    localparam int CTRL_DIR   = 2;
    localparam int CTRL_ROUTE = 8;

    localparam int ST_NV = 0;
    localparam int ST_TC = 1;
    localparam int ST_SW = 2;
endpackage

// File: rtl/fbdma_chan.sv
module fbdma_chan
    import fbdma_pkg::*;
#(
    parameter int AW  = 24,
    parameter int CW  = 24,
    parameter int RSW = 2,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [DW-1:0]  wdata,
    input  logic           xfer,
    output logic           en,
    output logic           chain,
    output logic           dir,
    output logic [RSW-1:0] route,
    output logic [AW-1:0]  cur_addr,
    output logic [CW-1:0]  cur_cnt,
    output logic [AW-1:0]  nxt_addr,
    output logic [CW-1:0]  nxt_cnt,
    output logic           nv,
    output logic           tc_flag,
    output logic           sw_flag,
    output logic           last
);
    typedef struct packed {
        logic           en;
        logic           chain;
        logic           dir;
        logic [RSW-1:0] route;
        logic [AW-1:0]  addr;
        logic [CW-1:0]  cnt;
        logic [AW-1:0]  naddr;
        logic [CW-1:0]  ncnt;
        logic           nv;
        logic           tcf;
        logic           swf;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     unused_wd;

    assign unused_wd = ^wdata;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    st_d.en    = wdata[CTRL_EN];
                    st_d.chain = wdata[CTRL_CHAIN];
                    st_d.dir   = wdata[CTRL_DIR];
                    st_d.route = wdata[CTRL_ROUTE +: RSW];
                end
                SEL_CADDR: st_d.addr  = wdata[AW-1:0];
                SEL_CCNT:  st_d.cnt   = wdata[CW-1:0];
                SEL_NADDR: st_d.naddr = wdata[AW-1:0];
                SEL_NCNT:  st_d.ncnt  = wdata[CW-1:0];
                SEL_STAT: begin
                    st_d.nv = wdata[ST_NV];
                    if (wdata[ST_TC]) st_d.tcf = 1'b0;
                    if (wdata[ST_SW]) st_d.swf = 1'b0;
                end
                default: ;
            endcase
        end
        if (xfer) begin
            if (st_q.cnt == '0) begin
                if (st_q.chain && st_q.nv) begin
                    st_d.addr = st_q.naddr;
                    st_d.cnt  = st_q.ncnt;
                    st_d.nv   = 1'b0;
                    st_d.swf  = 1'b1;
                end else begin
                    st_d.en  = 1'b0;
                    st_d.tcf = 1'b1;
                end
            end else begin
                st_d.addr = st_q.addr + 1'b1;
                st_d.cnt  = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en       = st_q.en;
    assign chain    = st_q.chain;
    assign dir      = st_q.dir;
    assign route    = st_q.route;
    assign cur_addr = st_q.addr;
    assign cur_cnt  = st_q.cnt;
    assign nxt_addr = st_q.naddr;
    assign nxt_cnt  = st_q.ncnt;
    assign nv       = st_q.nv;
    assign tc_flag  = st_q.tcf;
    assign sw_flag  = st_q.swf;
    assign last     = (st_q.cnt == '0);
endmodule

// File: rtl/fbdma_arb.sv
module fbdma_arb #(
    parameter int NCH  = 4,
    parameter int NREQ = 4,
    parameter int RSW  = 2,
    parameter int CHW  = 2
) (
    input  logic [NREQ-1:0] dreq,
    input  logic [NCH-1:0]  en,
    input  logic [RSW-1:0]  route [NCH],
    output logic            req_ok,
    output logic [CHW-1:0]  gnt
);
    logic [NCH-1:0] want;

    for (genvar c = 0; c < NCH; c++) begin : g_want
        assign want[c] = en[c] & dreq[route[c]];
    end

    always_comb begin
        req_ok = 1'b0;
        gnt    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (want[i]) begin
                req_ok = 1'b1;
                gnt    = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/fbdma_top.sv
module fbdma_top
    import fbdma_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NREQ = 4,
    parameter int AW   = 24,
    parameter int CW   = 24,
    parameter int DW   = 32,
    localparam int CHW = $clog2(NCH),
    localparam int RSW = $clog2(NREQ),
    localparam int RAW = CHW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] dreq,
    output logic [NREQ-1:0] dack,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_stb,
    output logic            mem_we,
    output logic            tc_o,
    output logic [NCH-1:0]  irq,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata
);
    typedef struct packed {
        logic           busy;
        logic [CHW-1:0] ch;
    } eng_st_t;

    eng_st_t eng_d, eng_q;

    logic [NCH-1:0] en_v, chain_v, dir_v, nv_v, tcf_v, swf_v, last_v, xfer_v, wr_v;
    logic [RSW-1:0] route_a   [NCH];
    logic [AW-1:0]  caddr_a   [NCH];
    logic [CW-1:0]  ccnt_a    [NCH];
    logic [AW-1:0]  naddr_a   [NCH];
    logic [CW-1:0]  ncnt_a    [NCH];
    logic           req_ok;
    logic [CHW-1:0] gnt;
    logic [CHW-1:0] rch;
    logic [2:0]     rsel;

    assign rch  = reg_addr[RAW-1:3];
    assign rsel = reg_addr[2:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign wr_v[c]   = reg_wr && (rch == CHW'(c));
        assign xfer_v[c] = eng_q.busy && (eng_q.ch == CHW'(c));

        fbdma_chan #(.AW(AW), .CW(CW), .RSW(RSW), .DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_v[c]),
            .wr_sel   (rsel),
            .wdata    (reg_wdata),
            .xfer     (xfer_v[c]),
            .en       (en_v[c]),
            .chain    (chain_v[c]),
            .dir      (dir_v[c]),
            .route    (route_a[c]),
            .cur_addr (caddr_a[c]),
            .cur_cnt  (ccnt_a[c]),
            .nxt_addr (naddr_a[c]),
            .nxt_cnt  (ncnt_a[c]),
            .nv       (nv_v[c]),
            .tc_flag  (tcf_v[c]),
            .sw_flag  (swf_v[c]),
            .last     (last_v[c])
        );
    end

    fbdma_arb #(.NCH(NCH), .NREQ(NREQ), .RSW(RSW), .CHW(CHW)) u_arb (
        .dreq   (dreq),
        .en     (en_v),
        .route  (route_a),
        .req_ok (req_ok),
        .gnt    (gnt)
    );

    always_comb begin
        eng_d = eng_q;
        if (eng_q.busy) begin
            eng_d.busy = 1'b0;
        end else if (req_ok) begin
            eng_d.busy = 1'b1;
            eng_d.ch   = gnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    always_comb begin
        dack = '0;
        if (eng_q.busy) dack[route_a[eng_q.ch]] = 1'b1;
    end

    assign mem_stb  = eng_q.busy;
    assign mem_addr = caddr_a[eng_q.ch];
    assign mem_we   = eng_q.busy && dir_v[eng_q.ch];
    assign tc_o     = eng_q.busy && last_v[eng_q.ch];
    assign irq      = tcf_v | swf_v;

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(rsel))
            SEL_CTRL: begin
                reg_rdata[CTRL_EN]            = en_v[rch];
                reg_rdata[CTRL_CHAIN]         = chain_v[rch];
                reg_rdata[CTRL_DIR]           = dir_v[rch];
                reg_rdata[CTRL_ROUTE +: RSW]  = route_a[rch];
            end
            SEL_CADDR: reg_rdata[AW-1:0] = caddr_a[rch];
            SEL_CCNT:  reg_rdata[CW-1:0] = ccnt_a[rch];
            SEL_NADDR: reg_rdata[AW-1:0] = naddr_a[rch];
            SEL_NCNT:  reg_rdata[CW-1:0] = ncnt_a[rch];
            SEL_STAT: begin
                reg_rdata[ST_NV] = nv_v[rch];
                reg_rdata[ST_TC] = tcf_v[rch];
                reg_rdata[ST_SW] = swf_v[rch];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fbdma_chk.sv
module fbdma_chk #(
    parameter int NCH  = 4,
    parameter int NREQ = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] dreq,
    input logic [NREQ-1:0] dack,
    input logic            mem_stb,
    input logic            tc_o,
    input logic [NCH-1:0]  irq,
    input logic            reg_wr
);
    // R2
    stb_onecyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |=> !mem_stb);

    // R2
    dack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack) && ((|dack) == mem_stb));

    // R2
    stb_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> |(dack & $past(dreq)));

    // R4
    tc_in_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> mem_stb);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !mem_stb) |=> $stable(irq));
endmodule

bind fbdma_top fbdma_chk #(.NCH(NCH), .NREQ(NREQ)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dreq    (dreq),
    .dack    (dack),
    .mem_stb (mem_stb),
    .tc_o    (tc_o),
    .irq     (irq),
    .reg_wr  (reg_wr)
);

// File: tb/sim_fbdma_top.sv
module sim_fbdma_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic [23:0] mem_addr;
    logic        mem_stb, mem_we, tc_o;
    logic [3:0]  irq;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    fbdma_top u0 (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .dack(dack),
        .mem_addr(mem_addr), .mem_stb(mem_stb), .mem_we(mem_we), .tc_o(tc_o),
        .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [4:0] ra(input int c, input int sel);
        return 5'(c * 8 + sel);
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic observe(input int line, input int nexp, input int n0,
                           input logic [23:0] a0, input logic [23:0] a1, input bit we);
        int k = 0;
        logic [23:0] ea;
        logic exp_tc;
        dreq[line] = 1'b1;
        for (int cyc = 0; cyc < 2 * nexp + 6; cyc++) begin
            @(negedge clk);
            if (cyc == 0) check(mem_stb === 1'b1, "R2 strobe one cycle after request", 32'(mem_stb), 1);
            if (mem_stb === 1'b1) begin
                ea = (k < n0) ? a0 + 24'(k) : a1 + 24'(k - n0);
                exp_tc = (k == n0 - 1) || (k == nexp - 1);
                check(mem_addr === ea, "R3 address", 32'(mem_addr), 32'(ea));
                check(mem_we === we, "R3 direction", 32'(mem_we), 32'(we));
                check(dack === 4'(1 << line), "R7 acknowledge line", 32'(dack), 32'(1 << line));
                check(tc_o === exp_tc, "R4 terminal count", 32'(tc_o), 32'(exp_tc));
                k++;
            end else begin
                check(dack === 4'b0, "R2 dack idle", 32'(dack), 0);
            end
        end
        dreq[line] = 1'b0;
        check(k == nexp, "R4 R5 transfer count", 32'(k), 32'(nexp));
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mem_stb === 1'b0 && tc_o === 1'b0, "R1 strobe after reset", 32'(mem_stb), 0);
        check(dack === 4'b0, "R1 dack after reset", 32'(dack), 0);
        check(irq === 4'b0, "R1 irq after reset", 32'(irq), 0);
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 6; s++) begin
                rd(ra(c, s), v);
                check(v === 32'h0, "R1 register after reset", v, 0);
            end
        end

        // Sweep: every channel, counts 1..4, rotated routing, alternating direction
        for (int c = 0; c < 4; c++) begin
            for (int n = 1; n <= 4; n++) begin
                logic [23:0] base;
                int route;
                bit dirb, chb;
                base  = 24'(c * 24'h10000 + n * 24'h100);
                route = 3 - c;
                dirb  = n[0];
                chb   = (n == 2); // R5 chaining on but next-valid clear
                wr(ra(c, 1), 32'(base));
                wr(ra(c, 2), 32'(n - 1));
                wr(ra(c, 0), 32'(1 | (int'(chb) << 1) | (int'(dirb) << 2) | (route << 8)));
                observe(route, n, n, base, base, dirb);
                rd(ra(c, 0), v);
                check(v[0] === 1'b0, "R5 enable cleared", 32'(v[0]), 0);
                rd(ra(c, 5), v);
                check(v === 32'h2, "R5 status terminal flag", v, 2);
                check(irq === 4'(1 << c), "R10 irq raised", 32'(irq), 32'(1 << c));
                rd(ra(c, 1), v);
                check(v === 32'(base + 24'(n - 1)), "R9 final address", v, 32'(base + 24'(n - 1)));
                rd(ra(c, 2), v);
                check(v === 32'h0, "R9 final count", v, 0);
                wr(ra(c, 5), 32'h2);
                check(irq === 4'b0, "R10 irq cleared", 32'(irq), 0);
            end
        end

        // R6 chaining: 3 items at 0x300, then 2 items at 0x500 without software action
        wr(ra(1, 1), 32'h300);
        wr(ra(1, 2), 32'd2);
        wr(ra(1, 3), 32'h500);
        wr(ra(1, 4), 32'd1);
        wr(ra(1, 5), 32'h1);
        rd(ra(1, 5), v);
        check(v === 32'h1, "R9 next-valid readback", v, 1);
        wr(ra(1, 0), 32'h203);
        observe(2, 5, 3, 24'h300, 24'h500, 1'b0);
        rd(ra(1, 5), v);
        check(v === 32'h6, "R6 switch and terminal flags, next-valid cleared", v, 6);
        check(irq === 4'b0010, "R10 irq for chained channel", 32'(irq), 2);
        wr(ra(1, 5), 32'h4);
        rd(ra(1, 5), v);
        check(v === 32'h2, "R10 switch flag cleared alone", v, 2);
        wr(ra(1, 5), 32'h2);

        // R8 priority: channel 0 (line 1) and channel 2 (line 3) requesting together
        wr(ra(0, 1), 32'h40);
        wr(ra(0, 2), 32'd1);
        wr(ra(0, 0), 32'h101);
        wr(ra(2, 1), 32'h80);
        wr(ra(2, 2), 32'd1);
        wr(ra(2, 0), 32'h301);
        begin
            int k = 0;
            dreq = 4'b1010;
            for (int cyc = 0; cyc < 12; cyc++) begin
                @(negedge clk);
                if (mem_stb === 1'b1) begin
                    logic [3:0] el;
                    logic [23:0] ea;
                    el = (k < 2) ? 4'b0010 : 4'b1000;
                    ea = (k < 2) ? 24'h40 + 24'(k) : 24'h80 + 24'(k - 2);
                    check(dack === el, "R8 lowest channel first", 32'(dack), 32'(el));
                    check(mem_addr === ea, "R8 address order", 32'(mem_addr), 32'(ea));
                    k++;
                end
            end
            dreq = 4'b0;
            check(k == 4, "R8 total transfers", 32'(k), 4);
        end
        check(irq === 4'b0101, "R10 irq both channels", 32'(irq), 5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule